// File: doc/BRIEF.md
# Context-Cache Invalidation Command Register

This block is a 64-bit memory-mapped command register. Software uses it to make a remapping unit drop entries from its context cache. Software first selects a scope in a two-bit field. It then writes the top byte of the register with the request bit set. A small sequencer then takes over. If a capability input says pending writes must be drained first, it runs a flush handshake with the write buffer. It then presents an invalidation request carrying the chosen scope to the cache. When the cache reports completion, the sequencer clears the request bit and records the scope the cache actually applied, which may not match the one requested.

Software polls the request bit to detect completion. While the bit reads 1, the register accepts no writes, so only one request can be outstanding at a time.

The register decodes at byte offset 0x28 (the 8-byte word covering 0x28..0x2F). It has a simple read/write port with byte enables. Field layout:

| Bits | Access | Meaning |
|------|--------|---------|
| 63 | set by software, cleared by hardware | request in progress |
| 62:61 | RW | requested scope (01 global, 10 domain, 11 device, 00 reserved) |
| 60:59 | RO | scope applied at the last completion |
| 58:34 | RO | zero |
| 33:0 | RW | qualifier (domain and source tags) |

Top module: `ctx_inval_cmd`

## Requirements
- R1: After reset the register reads all zeros and neither `flush_req` nor `inv_valid` is asserted.
- R2: A write to offset 0x28 updates bits 62:61 and 33:0 only in byte lanes whose enable is 1. Bits 58:34 always read 0. The new value is visible on `rd_data` from the cycle after the write.
- R3: An operation starts only when byte lane 7 is enabled and data bit 63 is 1. From the next cycle, bit 63 reads 1. A write with data bit 63 set that leaves lane 7 disabled starts nothing.
- R4: While bit 63 reads 1, every write to the register is ignored, including writes that try to clear bit 63.
- R5: When `cap_flush` is 1 at the start, `flush_req` rises in the next cycle and stays high until `flush_ack`. `inv_valid` stays low until the flush is acknowledged.
- R6: When `cap_flush` is 0 at the start, `flush_req` stays low and `inv_valid` rises in the cycle after the starting write.
- R7: `inv_valid` stays high with `inv_gran` equal to bits 62:61 and stable until `inv_ready` is seen. It then drops.
- R8: The cycle after an `inv_done` pulse, bit 63 still reads 1. From the following cycle, bit 63 reads 0 and bits 60:59 hold the `inv_done_gran` value.
- R9: A start with requested scope 00 issues neither a flush nor an invalidation. Bit 63 reads 1 for one cycle, then 0, and bits 60:59 become 00.
- R10: Bits 60:59 change only at completion. Software writes never alter them.
- R11: Reads at any other word return 0. Writes to any other word change nothing and start nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| wr_en | input | 1 | write strobe |
| wr_addr | input | ADDR_W | write byte address |
| wr_be | input | 8 | write byte enables, bit i for bits 8i+7:8i |
| wr_data | input | 64 | write data |
| rd_addr | input | ADDR_W | read byte address |
| rd_data | output | 64 | read data, combinational |
| cap_flush | input | 1 | write buffer must be flushed before invalidation |
| flush_req | output | 1 | flush request, held until acknowledged |
| flush_ack | input | 1 | flush complete |
| inv_valid | output | 1 | invalidation request valid |
| inv_ready | input | 1 | cache accepts the request |
| inv_gran | output | 2 | scope of the invalidation request |
| inv_done | input | 1 | one-cycle completion pulse from the cache |
| inv_done_gran | input | 2 | scope actually applied, valid with `inv_done` |

## Verification
The assertions check the following on every cycle:
- the flush request is held until acknowledged, and no invalidation request appears during a flush;
- an invalidation request stays stable until it is accepted;
- no traffic appears while any handshake output is active without the request bit set, or for reserved-scope requests;
- the fields stay frozen while busy;
- the applied-scope field is unchanged outside completion;
- the request bit rises only after a top-byte write with bit 63 set.

Only the bench's scenarios can show the exact latencies and the values read back. These cover:
- every byte-enable pattern;
- every requested scope crossed with flush on and off and several handshake delays;
- the reported scope differing from the requested one;
- writes attempted during an operation being dropped.

// File: rtl/cic_pkg.sv
package cic_pkg;

  localparam int REG_W    = 64;
  localparam int LANES    = REG_W / 8;
  localparam int BIT_REQ  = 63;
  localparam int GREQ_LO  = 61;
  localparam int GACT_LO  = 59;
  localparam int TOP_LANE = LANES - 1;

  typedef logic [1:0] gran_t;

  localparam gran_t GR_RSVD   = 2'b00;
  localparam gran_t GR_GLOBAL = 2'b01;
  localparam gran_t GR_DOMAIN = 2'b10;
  localparam gran_t GR_DEVICE = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_INVAL_REQ,
    ST_INVAL_WAIT,
    ST_DONE
  } seq_state_e;

  // Expand byte enables into a per-bit mask.
  function automatic logic [REG_W-1:0] lane_mask(input logic [LANES-1:0] be);
    logic [REG_W-1:0] m;
    for (int i = 0; i < LANES; i++) begin
      m[i*8 +: 8] = {8{be[i]}};
    end
    return m;
  endfunction

  // Bits software may modify: requested scope plus the qualifier.
  function automatic logic [REG_W-1:0] sw_mask(input int qual_w);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < REG_W; i++) begin
      if (i < qual_w) m[i] = 1'b1;
    end
    m[GREQ_LO]   = 1'b1;
    m[GREQ_LO+1] = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] merge_bits(input logic [REG_W-1:0] old_v,
                                                  input logic [REG_W-1:0] new_v,
                                                  input logic [REG_W-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  function automatic logic word_hit(input logic [63:0] addr, input logic [63:0] base);
    return (addr >> 3) == (base >> 3);
  endfunction

endpackage

// File: rtl/cic_wr_decode.sv
module cic_wr_decode
  import cic_pkg::*;
#(
  parameter int          ADDR_W = 12,
  parameter logic [63:0] BASE   = 64'h28,
  parameter int          QUAL_W = 34
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_be,
  input  logic [2:0]        wr_top,      // wr_data[63:61]
  input  logic              busy,
  output logic              wr_hit,
  output logic [REG_W-1:0]  bit_mask,
  output logic              start,
  output gran_t             start_gran
);

  localparam logic [REG_W-1:0] SWM = sw_mask(QUAL_W);

  logic addr_ok;

  always_comb begin
    addr_ok    = word_hit(64'(wr_addr), BASE);
    wr_hit     = wr_en && addr_ok && !busy;
    bit_mask   = lane_mask(wr_be) & SWM;
    start      = wr_hit && wr_be[TOP_LANE] && wr_top[2];
    start_gran = wr_top[1:0];
  end

endmodule

// File: rtl/cic_seq.sv
module cic_seq
  import cic_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  gran_t start_gran,
  input  gran_t req_gran,
  input  logic  cap_flush,
  input  logic  flush_ack,
  input  logic  inv_ready,
  input  logic  inv_done,
  input  gran_t inv_done_gran,
  output logic  flush_req,
  output logic  inv_valid,
  output gran_t inv_gran,
  output logic  done_evt,
  output gran_t done_gran
);

  seq_state_e state_q, state_d;
  gran_t      dg_q, dg_d;

  always_comb begin
    state_d = state_q;
    dg_d    = dg_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          dg_d = GR_RSVD;
          if (start_gran == GR_RSVD) state_d = ST_DONE;
          else if (cap_flush)        state_d = ST_FLUSH;
          else                       state_d = ST_INVAL_REQ;
        end
      end
      ST_FLUSH:      if (flush_ack) state_d = ST_INVAL_REQ;
      ST_INVAL_REQ:  if (inv_ready) state_d = ST_INVAL_WAIT;
      ST_INVAL_WAIT: begin
        if (inv_done) begin
          dg_d    = inv_done_gran;
          state_d = ST_DONE;
        end
      end
      ST_DONE:       state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dg_q    <= GR_RSVD;
    end else begin
      state_q <= state_d;
      dg_q    <= dg_d;
    end
  end

  assign flush_req = (state_q == ST_FLUSH);
  assign inv_valid = (state_q == ST_INVAL_REQ);
  assign inv_gran  = req_gran;
  assign done_evt  = (state_q == ST_DONE);
  assign done_gran = dg_q;

endmodule

// File: rtl/cic_regfile.sv
module cic_regfile
  import cic_pkg::*;
#(
  parameter int          ADDR_W = 12,
  parameter logic [63:0] BASE   = 64'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [REG_W-1:0]  bit_mask,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              start,
  input  logic              done_evt,
  input  gran_t             done_gran,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  reg_q,
  output logic [REG_W-1:0]  rd_data,
  output logic              busy
);

  logic [REG_W-1:0] reg_d;

  always_comb begin
    reg_d = reg_q;
    if (wr_hit) reg_d = merge_bits(reg_q, wr_data, bit_mask);
    if (start)  reg_d[BIT_REQ] = 1'b1;
    if (done_evt) begin
      reg_d[BIT_REQ]               = 1'b0;
      reg_d[GACT_LO+1:GACT_LO]     = done_gran;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= '0;
    else        reg_q <= reg_d;
  end

  assign busy    = reg_q[BIT_REQ];
  assign rd_data = word_hit(64'(rd_addr), BASE) ? reg_q : '0;

endmodule

// File: rtl/ctx_inval_cmd.sv
module ctx_inval_cmd
  import cic_pkg::*;
#(
  parameter int          ADDR_W = 12,
  parameter logic [63:0] BASE   = 64'h28,
  parameter int          QUAL_W = 34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_be,
  input  logic [63:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [63:0]       rd_data,
  input  logic              cap_flush,
  output logic              flush_req,
  input  logic              flush_ack,
  output logic              inv_valid,
  input  logic              inv_ready,
  output logic [1:0]        inv_gran,
  input  logic              inv_done,
  input  logic [1:0]        inv_done_gran
);

  logic             busy_w;
  logic             wr_hit_w;
  logic [REG_W-1:0] bit_mask_w;
  logic             start_w;
  gran_t            start_gran_w;
  logic             done_evt_w;
  gran_t            done_gran_w;
  logic [REG_W-1:0] reg_q_w;

  cic_wr_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .QUAL_W(QUAL_W)) u_dec (
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_be      (wr_be),
    .wr_top     (wr_data[63:61]),
    .busy       (busy_w),
    .wr_hit     (wr_hit_w),
    .bit_mask   (bit_mask_w),
    .start      (start_w),
    .start_gran (start_gran_w)
  );

  cic_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start_w),
    .start_gran    (start_gran_w),
    .req_gran      (reg_q_w[GREQ_LO+1:GREQ_LO]),
    .cap_flush     (cap_flush),
    .flush_ack     (flush_ack),
    .inv_ready     (inv_ready),
    .inv_done      (inv_done),
    .inv_done_gran (inv_done_gran),
    .flush_req     (flush_req),
    .inv_valid     (inv_valid),
    .inv_gran      (inv_gran),
    .done_evt      (done_evt_w),
    .done_gran     (done_gran_w)
  );

  cic_regfile #(.ADDR_W(ADDR_W), .BASE(BASE)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (wr_hit_w),
    .bit_mask  (bit_mask_w),
    .wr_data   (wr_data),
    .start     (start_w),
    .done_evt  (done_evt_w),
    .done_gran (done_gran_w),
    .rd_addr   (rd_addr),
    .reg_q     (reg_q_w),
    .rd_data   (rd_data),
    .busy      (busy_w)
  );

endmodule

// File: rtl/cic_checker.sv
module cic_checker #(
  parameter int QUAL_W = 34
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_be7,
  input logic              wr_d63,
  input logic              flush_req,
  input logic              flush_ack,
  input logic              inv_valid,
  input logic              inv_ready,
  input logic [1:0]        inv_gran,
  input logic              busy,
  input logic [1:0]        gran_q,
  input logic [1:0]        act_q,
  input logic [QUAL_W-1:0] qual_q,
  input logic              done_evt
);

  AST_FLUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && !flush_ack |=> flush_req); // R5
  AST_NO_INVAL_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !inv_valid); // R5
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && !inv_ready |=> inv_valid && $stable(inv_gran)); // R7
  AST_REQ_GRAN: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> inv_gran == gran_q); // R7
  AST_TRAFFIC_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req || inv_valid |-> busy); // R3
  AST_START_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && wr_be7 && wr_d63)); // R3
  AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(gran_q) && $stable(qual_q)); // R4
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy); // R8
  AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && gran_q == 2'b00 |-> !flush_req && !inv_valid); // R9
  AST_ACT_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done_evt |=> $stable(act_q)); // R10

endmodule

bind ctx_inval_cmd cic_checker #(.QUAL_W(QUAL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_be7    (wr_be[7]),
  .wr_d63    (wr_data[63]),
  .flush_req (flush_req),
  .flush_ack (flush_ack),
  .inv_valid (inv_valid),
  .inv_ready (inv_ready),
  .inv_gran  (inv_gran),
  .busy      (busy_w),
  .gran_q    (reg_q_w[62:61]),
  .act_q     (reg_q_w[60:59]),
  .qual_q    (reg_q_w[QUAL_W-1:0]),
  .done_evt  (done_evt_w)
);

// File: tb/ctx_inval_cmd_test.sv
module ctx_inval_cmd_test;

  localparam int          AW   = 12;
  localparam logic [11:0] BASE = 12'h028;
  localparam int          QW   = 34;
  localparam logic [63:0] WMASK = (64'h3 << 61) | ((64'h1 << QW) - 64'h1);
  localparam logic [63:0] AMASK = 64'h3 << 59;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_be = '0;
  logic [63:0]   wr_data = '0;
  logic [AW-1:0] rd_addr = BASE;
  logic [63:0]   rd_data;
  logic          cap_flush = 1'b0;
  logic          flush_req;
  logic          flush_ack = 1'b0;
  logic          inv_valid;
  logic          inv_ready = 1'b0;
  logic [1:0]    inv_gran;
  logic          inv_done = 1'b0;
  logic [1:0]    inv_done_gran = '0;

  int  vectors = 0;
  int  miscompares = 0;
  bit  finished = 1'b0;

  logic [63:0] exp_sw = '0;   // software-visible writable bits
  logic [1:0]  exp_act = '0;  // applied scope

  always #2 clk = ~clk;

  ctx_inval_cmd #(.ADDR_W(AW), .BASE(64'h28), .QUAL_W(QW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cap_flush(cap_flush),
    .flush_req(flush_req), .flush_ack(flush_ack), .inv_valid(inv_valid),
    .inv_ready(inv_ready), .inv_gran(inv_gran), .inv_done(inv_done),
    .inv_done_gran(inv_done_gran)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expected_word(input logic busy_bit);
    return {busy_bit, 63'h0} | (exp_sw & WMASK) | (64'(exp_act) << 59);
  endfunction

  function automatic logic [63:0] be_bits(input logic [7:0] be);
    logic [63:0] m = '0;
    for (int i = 0; i < 8; i++) if (be[i]) m = m | (64'hFF << (8*i));
    return m;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] be, input logic [63:0] d);
    wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
    step();
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic busy_poke();
    do_write(BASE, 8'hFF, 64'h7FFF_FFFF_FFFF_FFFF);
  endtask

  task automatic run_inval(input logic [1:0] gran, input logic cap, input int dly);
    logic [1:0] dg;
    cap_flush = cap;
    do_write(BASE, 8'h80, {1'b1, gran, 2'b11, 59'h0});
    exp_sw[62:61] = gran;
    chk("R3 busy after start", 64'(rd_data[63]), 64'd1);
    if (gran == 2'b00) begin
      chk("R9 no flush", 64'(flush_req), 64'd0);
      chk("R9 no inval", 64'(inv_valid), 64'd0);
      step();
      exp_act = 2'b00;
      chk("R9 reserved completes", rd_data, expected_word(1'b0));
    end else begin
      if (cap) begin
        for (int i = 0; i < dly; i++) begin
          chk("R5 flush held", 64'(flush_req), 64'd1);
          chk("R5 no inval during flush", 64'(inv_valid), 64'd0);
          busy_poke();
        end
        chk("R5 flush req", 64'(flush_req), 64'd1);
        chk("R5 no inval before ack", 64'(inv_valid), 64'd0);
        flush_ack = 1'b1;
        step();
        flush_ack = 1'b0;
        chk("R5 flush dropped", 64'(flush_req), 64'd0);
      end else begin
        chk("R6 no flush", 64'(flush_req), 64'd0);
      end
      for (int i = 0; i < dly; i++) begin
        chk("R7 valid held", 64'(inv_valid), 64'd1);
        chk("R7 gran held", 64'(inv_gran), 64'(gran));
        busy_poke();
      end
      chk("R6 inval valid", 64'(inv_valid), 64'd1);
      chk("R7 inval gran", 64'(inv_gran), 64'(gran));
      inv_ready = 1'b1;
      step();
      inv_ready = 1'b0;
      chk("R7 valid drops", 64'(inv_valid), 64'd0);
      busy_poke();
      chk("R4 still busy", 64'(rd_data[63]), 64'd1);
      dg = gran ^ 2'(dly);
      inv_done = 1'b1; inv_done_gran = dg;
      step();
      inv_done = 1'b0; inv_done_gran = 2'b00;
      chk("R8 busy in done cycle", 64'(rd_data[63]), 64'd1);
      step();
      exp_act = dg;
      chk("R8 R4 completion word", rd_data, expected_word(1'b0));
    end
  endtask

  initial begin
    step();
    step();
    chk("R1 reset word", rd_data, 64'h0);
    chk("R1 reset flush", 64'(flush_req), 64'd0);
    chk("R1 reset inval", 64'(inv_valid), 64'd0);
    rst_n = 1'b1;
    step();

    // R2 / R10: every byte-enable pattern, request bit kept clear
    for (int b = 0; b < 256; b++) begin
      logic [63:0] d;
      logic [63:0] m;
      d = (64'h9E3779B97F4A7C15 * 64'(b + 1)) & ~(64'h1 << 63);
      m = be_bits(8'(b)) & WMASK;
      do_write(BASE, 8'(b), d);
      exp_sw = (exp_sw & ~m) | (d & m);
      chk("R2 R10 lane merge", rd_data, expected_word(1'b0));
      chk("R3 no start", 64'(inv_valid | flush_req), 64'd0);
    end

    // R11: other addresses
    rd_addr = BASE + 12'h8;
    step();
    chk("R11 read other word", rd_data, 64'h0);
    rd_addr = BASE;
    do_write(BASE + 12'h8, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF);
    do_write(BASE - 12'h8, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R11 foreign write ignored", rd_data, expected_word(1'b0));
    chk("R11 no start", 64'(inv_valid | flush_req), 64'd0);

    // R3: lower lanes with bit 63 data set start nothing
    do_write(BASE, 8'h7F, 64'hFFFF_FFFF_FFFF_FFFF);
    exp_sw = (exp_sw & ~(be_bits(8'h7F) & WMASK)) | (64'hFFFF_FFFF_FFFF_FFFF & be_bits(8'h7F) & WMASK);
    chk("R3 lower lanes only", rd_data, expected_word(1'b0));
    step();
    chk("R3 no request", 64'(inv_valid | flush_req), 64'd0);

    // R10: explicit attempt on applied-scope bits
    do_write(BASE, 8'h80, 64'h1800_0000_0000_0000);
    exp_sw[62:61] = 2'b00;
    chk("R10 applied scope read-only", rd_data & AMASK, 64'(exp_act) << 59);

    for (int g = 0; g < 4; g++)
      for (int c = 0; c < 2; c++)
        for (int dl = 0; dl < 3; dl++)
          run_inval(2'(g), c[0], dl);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule